// File: doc/BRIEF.md
# Buck Phase Gate Control Sequencer

This block is the digital control core for one phase of a multiphase synchronous buck converter. Each falling edge of the phase clock starts an on-time. A sampled comparator input ends the on-time when the modulation ramp passes the error voltage. The block turns the resulting duty signal into high-side and low-side gate enables. Each gate turns on only after the other gate's feedback shows it is off. The block also requests a ramp discharge while the on-time is over.

Fault inputs override normal switching in a fixed order: overvoltage, then debug isolation, then body braking, then the synchronous-rectifier disable. When the duty signal is still high at a new phase clock edge, the block forces the high side off. The high side stays off until the ramp is reported near its floor. Analog comparators, the ramp generator and the drivers are outside the block. All of their results arrive as synchronous digital inputs.

Top module: `buck_phase_seq`

## Requirements
- R1: The duty latch sets only in the cycle after a sampled high-to-low transition of `phase_clk_i`. It does not set when `ramp_trip_i` is high in that cycle, and a high level of `phase_clk_i` alone never sets it.
- R2: `ramp_trip_i` high clears the duty latch on the next edge and wins over a set. `disch_o` goes high when the latch clears and stays high until the latch sets again.
- R3: When the duty latch sets, `ls_en_o` drops first. `hs_en_o` rises only after `ls_fb_i` (high = low-side gate on) has been seen low. `hs_en_o` and `ls_en_o` are never high together.
- R4: When the duty latch clears, `hs_en_o` drops first. `ls_en_o` rises only after `hs_fb_i` (high = high-side gate on) has been seen low.
- R5: If the latch is still high at a new phase clock falling edge, the high side is forced off. It stays off, with `disch_o` high, until `ramp_floor_i` is seen high. The latch then sets again.
- R6: While `ovp_i` is high, `hs_en_o` is low from the next edge and `ls_en_o` is driven on. This holds regardless of every other input. Normal switching resumes once `ovp_i` falls.
- R7: `debug_i` high, when `ovp_i` is low, holds both enables low from the next edge.
- R8: `brake_i` high, when neither `ovp_i` nor `debug_i` is high, holds `ls_en_o` low from the next edge.
- R9: `low_vout_i` and `neg_cur_i` both high hold `ls_en_o` low. Either one alone has no effect.
- R10: A single low sample of the opposite gate's feedback is latched. The pending enable still rises even if the feedback returns high before the enable is granted.
- R11: If the opposite feedback never shows off, the pending enable rises after `NOVL_TMO` cycles of waiting.
- R12: During reset, `hs_en_o`, `ls_en_o` and `disch_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_clk_i | input | 1 | Sampled phase clock; a falling edge starts an on-time |
| ramp_trip_i | input | 1 | Ramp has exceeded the error voltage |
| ramp_floor_i | input | 1 | Ramp is within 200 mV of the reference |
| brake_i | input | 1 | Error voltage is below the ramp floor |
| ovp_i | input | 1 | Overvoltage flag |
| debug_i | input | 1 | Phase isolation request |
| low_vout_i | input | 1 | Local output is below 75 % of the reference |
| neg_cur_i | input | 1 | Negative inductor current detected |
| hs_fb_i | input | 1 | High-side gate feedback, high = on |
| ls_fb_i | input | 1 | Low-side gate feedback, high = on |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| disch_o | output | 1 | Ramp discharge request |

## Verification
The bench builds the block with `NOVL_TMO` set to 8. With that value, a stuck gate feedback releases the pending enable within about a dozen cycles. The bench can then check both sides of the window: still off early, on after the limit. For the other tests, the bench models the gate feedback as an echo of each enable one cycle later, so the normal handshake settles in a few cycles. The override priorities are checked with the duty latch idle. The overvoltage and debug overrides are checked again with the latch high, where they must also pull the high side down.

// File: rtl/buck_phase_pkg.sv
package buck_phase_pkg;
  typedef enum logic [2:0] {
    OVR_NONE,
    OVR_OVP,
    OVR_DEBUG,
    OVR_BRAKE,
    OVR_SRD
  } ovr_e;

  typedef struct packed {
    logic hs;
    logic ls;
  } gate_req_t;
endpackage

// File: rtl/bps_duty_latch.sv
module bps_duty_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_clk_i,
  input  logic ramp_trip_i,
  input  logic ramp_floor_i,
  output logic duty_o,
  output logic disch_o
);
  logic phase_q, duty_q, hold_q, disch_q;
  logic duty_d, hold_d, disch_d;
  logic fall, force_off, resume;

  assign fall      = phase_q & ~phase_clk_i;
  assign force_off = fall & duty_q;
  assign resume    = hold_q & ramp_floor_i;

  always_comb begin
    duty_d = duty_q;
    hold_d = hold_q;
    if (force_off) begin
      duty_d = 1'b0;
      hold_d = 1'b1;
    end else if (resume) begin
      duty_d = 1'b1;
      hold_d = 1'b0;
    end else if (fall && !hold_q) begin
      duty_d = 1'b1;
    end
    // reset dominant
    if (ramp_trip_i) duty_d = 1'b0;
  end

  always_comb begin
    disch_d = disch_q;
    if (duty_q && !duty_d) disch_d = 1'b1;
    else if (duty_d) disch_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      duty_q  <= 1'b0;
      hold_q  <= 1'b0;
      disch_q <= 1'b0;
    end else begin
      phase_q <= phase_clk_i;
      duty_q  <= duty_d;
      hold_q  <= hold_d;
      disch_q <= disch_d;
    end
  end

  assign duty_o  = duty_q;
  assign disch_o = disch_q;

  // R2
  trip_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_trip_i |=> !duty_q);

  // R5
  hold_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !ramp_floor_i) |=> !duty_q);

  // R1
  set_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!duty_q && !hold_q && !(phase_q && !phase_clk_i)) |=> !duty_q);
endmodule

// File: rtl/bps_override.sv
module bps_override
  import buck_phase_pkg::*;
(
  input  logic      duty_i,
  input  logic      ovp_i,
  input  logic      debug_i,
  input  logic      brake_i,
  input  logic      low_vout_i,
  input  logic      neg_cur_i,
  output gate_req_t req_o
);
  ovr_e cause;

  always_comb begin
    if (ovp_i)                       cause = OVR_OVP;
    else if (debug_i)                cause = OVR_DEBUG;
    else if (brake_i)                cause = OVR_BRAKE;
    else if (low_vout_i && neg_cur_i) cause = OVR_SRD;
    else                             cause = OVR_NONE;
  end

  always_comb begin
    unique case (cause)
      OVR_OVP:   req_o = '{hs: 1'b0,   ls: 1'b1};
      OVR_DEBUG: req_o = '{hs: 1'b0,   ls: 1'b0};
      OVR_BRAKE,
      OVR_SRD:   req_o = '{hs: duty_i, ls: 1'b0};
      default:   req_o = '{hs: duty_i, ls: !duty_i};
    endcase
  end
endmodule

// File: rtl/bps_novl_chan.sv
module bps_novl_chan #(
  parameter int NOVL_TMO = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic other_en_i,
  input  logic other_fb_i,
  output logic en_o
);
  localparam int CNT_W = $clog2(NOVL_TMO + 1);

  logic             en_q, ok_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pending, tmo_hit;

  assign pending = req_i & ~en_q & ~other_en_i;
  assign tmo_hit = (cnt_q == CNT_W'(NOVL_TMO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      // off-confirmation is sticky while waiting
      ok_q  <= pending & (ok_q | ~other_fb_i);
      cnt_q <= !pending ? '0 : (tmo_hit ? cnt_q : cnt_q + 1'b1);
      if (!req_i) en_q <= 1'b0;
      else if (pending && (ok_q || tmo_hit)) en_q <= 1'b1;
    end
  end

  assign en_o = en_q;

  // R11
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NOVL_TMO));

  // R11
  tmo_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && tmo_hit) |=> en_q);

  // R10
  ok_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending && ok_q) |=> en_q);
endmodule

// File: rtl/buck_phase_seq.sv
module buck_phase_seq
  import buck_phase_pkg::*;
#(
  parameter int NOVL_TMO = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_clk_i,
  input  logic ramp_trip_i,
  input  logic ramp_floor_i,
  input  logic brake_i,
  input  logic ovp_i,
  input  logic debug_i,
  input  logic low_vout_i,
  input  logic neg_cur_i,
  input  logic hs_fb_i,
  input  logic ls_fb_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic disch_o
);
  localparam int NSIDE = 2;  // 0 = high side, 1 = low side

  logic      duty;
  gate_req_t req;
  logic [NSIDE-1:0] side_req, side_fb, side_en;

  bps_duty_latch u_duty (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_clk_i (phase_clk_i),
    .ramp_trip_i (ramp_trip_i),
    .ramp_floor_i(ramp_floor_i),
    .duty_o      (duty),
    .disch_o     (disch_o)
  );

  bps_override u_ovr (
    .duty_i    (duty),
    .ovp_i     (ovp_i),
    .debug_i   (debug_i),
    .brake_i   (brake_i),
    .low_vout_i(low_vout_i),
    .neg_cur_i (neg_cur_i),
    .req_o     (req)
  );

  assign side_req = {req.ls, req.hs};
  assign side_fb  = {ls_fb_i, hs_fb_i};

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    bps_novl_chan #(.NOVL_TMO(NOVL_TMO)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (side_req[g]),
      .other_en_i(side_en[NSIDE-1-g]),
      .other_fb_i(side_fb[NSIDE-1-g]),
      .en_o      (side_en[g])
    );
  end

  assign hs_en_o = side_en[0];
  assign ls_en_o = side_en[1];

  // R3
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_o && ls_en_o));

  // R6
  ovp_hs_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovp_i |=> !hs_en_o);

  // R7
  debug_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (debug_i && !ovp_i) |=> (!hs_en_o && !ls_en_o));

  // R8
  brake_ls_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brake_i && !ovp_i) |=> !ls_en_o);

  // R9
  srd_ls_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_vout_i && neg_cur_i && !ovp_i) |=> !ls_en_o);

  // R12
  always_comb begin
    if (!rst_ni) reset_low_chk: assert (!hs_en_o && !ls_en_o && !disch_o);
  end
endmodule

// File: tb/buck_phase_seq_tb_top.sv
module buck_phase_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_clk = 0, ramp_trip = 0, ramp_floor = 0, brake = 0, ovp = 0;
  logic debug = 0, low_vout = 0, neg_cur = 0, hs_fb = 0, ls_fb = 0;
  logic hs_en, ls_en, disch;
  logic auto_fb = 1'b1;
  int   errors = 0, checks = 0, overlaps = 0;
  bit   done = 1'b0;

  // {ovp, debug, brake, low_vout, neg_cur, expected ls_en}
  localparam logic [5:0] VEC [7] = '{
    6'b000001, 6'b111111, 6'b010000, 6'b001000,
    6'b000110, 6'b000101, 6'b000011
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  buck_phase_seq #(.NOVL_TMO(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_clk_i(phase_clk),
    .ramp_trip_i(ramp_trip), .ramp_floor_i(ramp_floor), .brake_i(brake),
    .ovp_i(ovp), .debug_i(debug), .low_vout_i(low_vout), .neg_cur_i(neg_cur),
    .hs_fb_i(hs_fb), .ls_fb_i(ls_fb), .hs_en_o(hs_en), .ls_en_o(ls_en),
    .disch_o(disch)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      if (hs_en && ls_en) overlaps++;
      if (auto_fb) begin
        hs_fb = hs_en;
        ls_fb = ls_en;
      end
    end
  endtask

  task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {hs,ls,disch} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic phase_pulse();
    phase_clk = 1'b1;
    tick();
    phase_clk = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    chk("R12 reset", {hs_en, ls_en, disch}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
    tick(4);
    chk("R4 idle low side on", {hs_en, ls_en, disch}, 3'b010);

    // override priority with duty latch idle: R6 R7 R8 R9
    foreach (VEC[i]) begin
      {ovp, debug, brake, low_vout, neg_cur} = VEC[i][5:1];
      tick(5);
      chk_bit($sformatf("R6/R7/R8/R9 row %0d ls", i), ls_en, VEC[i][0]);
      chk_bit($sformatf("R6/R7/R8/R9 row %0d hs", i), hs_en, 1'b0);
    end
    {ovp, debug, brake, low_vout, neg_cur} = '0;
    tick(4);

    // R1: trip blocks set; high level alone does not set
    ramp_trip = 1'b1;
    phase_pulse();
    ramp_trip = 1'b0;
    tick(5);
    chk("R1 set blocked by trip", {hs_en, ls_en, disch}, 3'b010);
    phase_clk = 1'b1;
    tick(5);
    chk("R1 high level no set", {hs_en, ls_en, disch}, 3'b010);
    phase_clk = 1'b0;
    tick();
    chk_bit("R3 low side drops first", ls_en, 1'b1);
    tick(5);
    chk("R3 high side on after edge", {hs_en, ls_en, disch}, 3'b100);

    // R2: trip clears, discharge until next set
    ramp_trip = 1'b1;
    tick();
    ramp_trip = 1'b0;
    tick(5);
    chk("R2/R4 cleared", {hs_en, ls_en, disch}, 3'b011);
    phase_pulse();
    chk_bit("R2 discharge ends at set", disch, 1'b0);
    tick(5);
    chk("R2 back on", {hs_en, ls_en, disch}, 3'b100);

    // R5: forced off at edge while still high
    phase_pulse();
    tick(6);
    chk("R5 forced off", {hs_en, ls_en, disch}, 3'b011);
    tick(4);
    chk("R5 held off without floor", {hs_en, ls_en, disch}, 3'b011);
    ramp_floor = 1'b1;
    tick();
    ramp_floor = 1'b0;
    tick(5);
    chk("R5 resumed at floor", {hs_en, ls_en, disch}, 3'b100);

    // R6 with duty high
    ovp = 1'b1;
    tick();
    chk_bit("R6 hs off next edge", hs_en, 1'b0);
    tick(5);
    chk("R6 low side forced", {hs_en, ls_en, disch}, 3'b010);
    ovp = 1'b0;
    tick(6);
    chk("R6 released", {hs_en, ls_en, disch}, 3'b100);

    // R7 with duty high
    debug = 1'b1;
    tick(3);
    chk("R7 both off", {hs_en, ls_en, disch}, 3'b000);
    debug = 1'b0;
    tick(6);
    chk("R7 released", {hs_en, ls_en, disch}, 3'b100);

    // R10: single low feedback sample latched
    auto_fb = 1'b0;
    hs_fb = 1'b1;
    ls_fb = 1'b0;
    ramp_trip = 1'b1;
    tick();
    ramp_trip = 1'b0;
    tick(3);
    chk_bit("R4 ls waits for hs feedback", ls_en, 1'b0);
    hs_fb = 1'b0;
    tick();
    hs_fb = 1'b1;
    tick(2);
    chk_bit("R10 latched confirmation", ls_en, 1'b1);

    // R11: stuck low-side feedback, timeout release
    ls_fb = 1'b1;
    phase_pulse();
    tick(4);
    chk_bit("R11 waiting before timeout", hs_en, 1'b0);
    tick(TMO + 4);
    chk_bit("R11 released by timeout", hs_en, 1'b1);
    auto_fb = 1'b1;
    tick(2);

    chk_bit("R3 never overlapped", overlaps != 0, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule